// File: doc/BRIEF.md
# Block Parity Accumulator

This block folds a fixed-length block of data words into one word by bitwise XOR. A single-cycle start pulse marks the first word of a block. Words arrive one per clock, with no gaps. The block keeps two pieces of state: an accumulated parity word and a down-counter of the words still to come. When the last word of the block has been absorbed, the done flag goes high. The parity output then holds its value until the next start pulse.

The start word is loaded straight into the accumulator instead of being XORed into it, so no separate clear cycle is needed between blocks. A start pulse that comes while done is high opens a new block on that same cycle. A start pulse that comes in the middle of a block drops the partial result and begins counting again from the new word. Block length and word width are parameters. The defaults are 16 words of 8 bits.

Top module: `hpar_engine`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, parity reads zero and done reads one, whatever start and data carry.
- R2: A clock edge that samples start high loads parity with that cycle's data word and drives done low.
- R3: On each edge with start low and done low, parity becomes its previous value XOR the data word sampled at that edge.
- R4: After a start edge, done stays low for the next WORDS-1 edges and rises on the edge that absorbs the last word. Parity is then the XOR of exactly the start word and the WORDS-1 words after it.
- R5: While done is high and start stays low, parity and done do not change, whatever data is presented.
- R6: A start sampled while done is high begins a new block on that edge, with no idle cycle in between.
- R7: A start sampled in the middle of a block discards the partial result. The new block's result and done timing depend only on the new start word and the words after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | High on the cycle carrying the first word of a block |
| din | input | WIDTH | Data word, one accepted per cycle |
| parity | output | WIDTH | Accumulated XOR; held once the block is complete |
| done | output | 1 | High when no words of the current block remain |

## Verification
Every result is due one clock edge after the stimulus that causes it. The start load and each XOR step show on parity right after the edge that samples them. Done goes low on the start edge and rises on the edge that samples the last word, which is the WORDS-th edge counted from and including the start edge. The bench drives inputs on the falling edge and samples 1 ns after each rising edge, so each check sees exactly one register update. Done is checked after every word of a block, so a block one word too short or too long is caught at the exact cycle where it goes wrong.

// File: rtl/hpar_engine.sv
module hpar_engine #(
  parameter int WIDTH = 8,
  parameter int WORDS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] parity,
  output logic             done
);
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

  logic [WIDTH-1:0] acc;
  logic [CW-1:0]    left;

  assign done   = (left == '0);
  assign parity = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      left <= '0;
    end else if (start) begin
      acc  <= din;
      left <= LAST;
    end else if (!done) begin
      acc  <= acc ^ din;
      left <= left - CW'(1);
    end
  end
endmodule

// File: rtl/hpar_engine_chk.sv
module hpar_engine_chk #(
  parameter int WIDTH = 8,
  parameter int WORDS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] parity,
  input logic             done
);
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [CW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since <= '0;
    else if (start)           since <= CW'(WORDS - 1);
    else if (since != '0)     since <= since - CW'(1);
  end

  always_comb begin
    if (!rst_n) p_reset_state_r1: assert (parity == '0 && done);
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (parity == $past(din)) && !done);

  p_accum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !done) |=> parity == ($past(parity) ^ $past(din)));

  p_done_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done == (since == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && done) |=> done && $stable(parity));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && done) |=> !done);
endmodule

bind hpar_engine hpar_engine_chk #(.WIDTH(WIDTH), .WORDS(WORDS)) u_chk (.*);

// File: tb/sim_hpar_engine.sv
`timescale 1ns/1ps
module sim_hpar_engine;
  localparam int W = 8;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] parity;
  logic         done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hpar_engine #(.WIDTH(W), .WORDS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .parity(parity), .done(done)
  );

  task automatic chk_par(input string tag, input logic [W-1:0] exp);
    checks++;
    if (parity !== exp) begin
      errors++;
      $display("FAIL %s parity got %h expected %h", tag, parity, exp);
    end
  endtask

  task automatic chk_done(input string tag, input logic exp);
    checks++;
    if (done !== exp) begin
      errors++;
      $display("FAIL %s done got %b expected %b", tag, done, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [W-1:0] d);
    @(negedge clk);
    start = s;
    din   = d;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [W-1:0] word_of(input int kind, input int i);
    case (kind)
      0:       return '0;
      1:       return '1;
      2:       return W'(i * 37 + 5);
      default: return W'($urandom);
    endcase
  endfunction

  task automatic run_block(input string first_tag, input int kind);
    logic [W-1:0] acc = '0;
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] w = word_of(kind, i);
      acc = (i == 0) ? w : (acc ^ w);
      drive(i == 0, w);
      chk_par((i == 0) ? first_tag : "R3", acc);
      if (i < N - 1) chk_done("R4 early", 1'b0);
      else begin
        chk_done("R4 final", 1'b1);
        chk_par("R4 result", acc);
      end
    end
  endtask

  task automatic t_reset();
    start = 1'b1;
    din   = '1;
    repeat (3) @(posedge clk);
    #1;
    chk_par("R1 in reset", '0);
    chk_done("R1 in reset", 1'b1);
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b1;
    drive(1'b0, 8'h3C);
    chk_par("R1 after release", '0);
    chk_done("R1 after release", 1'b1);
  endtask

  task automatic t_hold();
    logic [W-1:0] keep = parity;
    for (int i = 0; i < 6; i++) begin
      drive(1'b0, W'($urandom));
      chk_par("R5", keep);
      chk_done("R5", 1'b1);
    end
  endtask

  task automatic t_abort();
    drive(1'b1, 8'hA5);
    for (int i = 0; i < 6; i++) begin
      drive(1'b0, W'(i + 1));
      chk_done("R7 partial", 1'b0);
    end
    run_block("R7", 3);
  endtask

  initial begin
    t_reset();
    run_block("R2", 2);
    t_hold();
    run_block("R6", 1);
    run_block("R6", 0);
    t_hold();
    t_abort();
    run_block("R6", 3);
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule